// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU bus with 16-bit addresses and a cartridge that has more ROM and external RAM than that address space can reach. It translates each CPU read into a physical ROM or RAM address and returns the read byte. The lower ROM window always maps to bank 0. The upper ROM window maps to a selectable bank. The RAM window maps to a selectable RAM bank, and only answers while RAM is enabled.

The CPU sets up the banking by writing into the ROM address range. Those writes load a 7-bit bank register, a RAM-enable bit and a banking-mode bit. In ROM-banking mode, all seven bank bits form the ROM bank number and the RAM bank is 0. In RAM-banking mode, the ROM bank uses only the low five bits and bits 6:5 pick the RAM bank.

Requests use a valid/ready handshake on `req_*`. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. Only one read is handled at a time. `req_ready` stays low from the edge that accepts a read until the edge where its response is taken. A read's response appears on `rsp_valid`/`rsp_data` at the second rising edge after acceptance. The response holds unchanged until `rsp_ready` is seen high on a rising edge. Writes complete on the edge that accepts them and produce no response. The ROM and RAM are external synchronous memories: each returns the byte for the address presented with its read enable one clock later.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, the bank register holds 1, RAM is disabled and ROM-banking mode is selected.
- R2: A read in 0x0000–0x3FFF raises `rom_rd_en` and drives `rom_addr` equal to the CPU address (bank 0), whatever the bank register holds.
- R3: In ROM-banking mode, a read in 0x4000–0x7FFF drives `rom_addr` = (address − 0x4000) + bank × 0x4000, using all 7 bank bits.
- R4: In RAM-banking mode, the ROM bank for 0x4000–0x7FFF is the bank register ANDed with 0x1F.
- R5: With RAM enabled, a read in 0xA000–0xBFFF raises `ram_rd_en` and drives `ram_addr` = (address − 0xA000) + rb × 0x2000. Here rb is bank bits 6:5 in RAM-banking mode and 0 in ROM-banking mode.
- R6: With RAM disabled, a read in 0xA000–0xBFFF returns 0x00 and leaves `ram_rd_en` low.
- R7: A read outside 0x0000–0x7FFF and 0xA000–0xBFFF returns 0x00 and raises neither memory enable.
- R8: A write to 0x0000–0x1FFF enables RAM when data[3:0] is 0xA and disables it for any other value.
- R9: A write to 0x2000–0x3FFF loads data[4:0] into bank bits 4:0; a value of 0 in those five bits is stored as 1.
- R10: A write to 0x4000–0x5FFF loads data[1:0] into bank bits 6:5. A write to 0x6000–0x7FFF sets the mode from data[0]: 1 selects RAM-banking mode and 0 selects ROM-banking mode.
- R11: `rsp_valid` rises at the second rising edge after a read is accepted. It then holds, with `rsp_data` stable, until `rsp_ready` is high at an edge. `req_ready` is low while a read is outstanding.
- R12: Writes to addresses at or above 0x8000 leave the bank register, mode and RAM enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_data | output | 8 | Read data returned to the CPU |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rdata | input | 8 | ROM data, one cycle after the strobe |
| ram_rd_en | output | 1 | External RAM read strobe |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_rdata | input | 8 | RAM data, one cycle after the strobe |

## Verification
Some behaviours are checked by assertions on every cycle:
- the handshake rules, including that no new request is taken while a read is outstanding and that a held response stays stable;
- that the memory strobes fire only inside their address windows;
- that lower-window reads carry bank 0 and that RAM-mode ROM banks never use the top two bits;
- that the RAM bank is 0 in ROM-banking mode;
- that unmapped reads return zero.

Other behaviours depend on the order of CPU writes, so only the bench's directed scenarios can show them:
- the exact bank arithmetic;
- the substitution of 1 for a written zero;
- the effect of RAM enable and disable;
- the switching of modes;
- that writes above the ROM range are ignored.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW    = 16;
  localparam int ROM_OFS_W = 14;  // 16 KiB ROM window
  localparam int RAM_OFS_W = 13;  // 8 KiB RAM window

  typedef enum logic [1:0] {
    WIN_ROM_LO,
    WIN_ROM_HI,
    WIN_RAM,
    WIN_NONE
  } win_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_ROM,
    SRC_RAM
  } src_e;

  // Register selected by a write into the ROM range (address bits 14:13)
  typedef enum logic [1:0] {
    WSEL_RAMEN = 2'd0,
    WSEL_LO    = 2'd1,
    WSEL_HI    = 2'd2,
    WSEL_MODE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output win_e              win,
  output wsel_e             wsel
);
  always_comb begin
    if (!addr[15]) begin
      win = addr[14] ? WIN_ROM_HI : WIN_ROM_LO;
    end else if (addr[15:13] == 3'b101) begin
      win = WIN_RAM;
    end else begin
      win = WIN_NONE;
    end
    wsel = wsel_e'(addr[14:13]);
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int BANK_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wsel_e             wsel,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] bank,
  output logic              ram_on,
  output logic              mode_ram
);
  localparam logic [LO_W-1:0] LO_ONE = {{(LO_W-1){1'b0}}, 1'b1};

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_in;

  assign lo_in = (wdata[LO_W-1:0] == '0) ? LO_ONE : wdata[LO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= LO_ONE;
      hi_q     <= '0;
      ram_on   <= 1'b0;
      mode_ram <= 1'b0;
    end else if (wr_en) begin
      unique case (wsel)
        WSEL_RAMEN: ram_on   <= (wdata[3:0] == 4'hA);
        WSEL_LO:    lo_q     <= lo_in;
        WSEL_HI:    hi_q     <= wdata[HI_W-1:0];
        WSEL_MODE:  mode_ram <= wdata[0];
      endcase
    end
  end

  assign bank = {hi_q, lo_q};
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
  import cbc_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int BANK_W = LO_W + HI_W,
  localparam int ROM_AW = BANK_W + ROM_OFS_W,
  localparam int RAM_AW = HI_W + RAM_OFS_W
) (
  input  logic [CPU_AW-1:0] addr,
  input  win_e              win,
  input  logic [BANK_W-1:0] bank,
  input  logic              mode_ram,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [BANK_W-1:0] rom_bank;
  logic [HI_W-1:0]   ram_bank;

  always_comb begin
    if (win == WIN_ROM_LO) begin
      rom_bank = '0;
    end else if (mode_ram) begin
      rom_bank = {{HI_W{1'b0}}, bank[LO_W-1:0]};
    end else begin
      rom_bank = bank;
    end
    ram_bank = mode_ram ? bank[BANK_W-1:LO_W] : '0;
  end

  assign rom_addr = {rom_bank, addr[ROM_OFS_W-1:0]};
  assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};
endmodule

// File: rtl/cbc_resp.sv
module cbc_resp
  import cbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  src_e       src,
  input  logic [7:0] rom_rdata,
  input  logic [7:0] ram_rdata,
  input  logic       rsp_ready,
  output logic       busy,
  output logic       rsp_valid,
  output logic [7:0] rsp_data
);
  logic pend_q;
  src_e src_q;
  logic [7:0] sel_data;

  always_comb begin
    unique case (src_q)
      SRC_ROM: sel_data = rom_rdata;
      SRC_RAM: sel_data = ram_rdata;
      default: sel_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      src_q     <= SRC_ZERO;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      if (issue) begin
        pend_q <= 1'b1;
        src_q  <= src;
      end else if (pend_q) begin
        pend_q <= 1'b0;
      end
      if (pend_q) begin
        rsp_valid <= 1'b1;
        rsp_data  <= sel_data;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign busy = pend_q | rsp_valid;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int BANK_W = LO_W + HI_W,
  localparam int ROM_AW = BANK_W + ROM_OFS_W,
  localparam int RAM_AW = HI_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CPU_AW-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              ram_rd_en,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [7:0]        ram_rdata
);
  win_e              win;
  wsel_e             wsel;
  logic [BANK_W-1:0] bank;
  logic              ram_on;
  logic              mode_ram;
  logic              busy;
  logic              accept;
  logic              rd_go;
  logic              wr_go;
  src_e              src;

  cbc_decode u_dec (
    .addr (req_addr),
    .win  (win),
    .wsel (wsel)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign rd_go     = accept && !req_write;
  assign wr_go     = accept && req_write && (win == WIN_ROM_LO || win == WIN_ROM_HI);

  cbc_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_go),
    .wsel     (wsel),
    .wdata    (req_wdata),
    .bank     (bank),
    .ram_on   (ram_on),
    .mode_ram (mode_ram)
  );

  cbc_xlate #(.LO_W(LO_W), .HI_W(HI_W)) u_xl (
    .addr     (req_addr),
    .win      (win),
    .bank     (bank),
    .mode_ram (mode_ram),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr)
  );

  always_comb begin
    rom_rd_en = rd_go && (win == WIN_ROM_LO || win == WIN_ROM_HI);
    ram_rd_en = rd_go && (win == WIN_RAM) && ram_on;
    if (rom_rd_en)      src = SRC_ROM;
    else if (ram_rd_en) src = SRC_RAM;
    else                src = SRC_ZERO;
  end

  cbc_resp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (rd_go),
    .src       (src),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rsp_ready (rsp_ready),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [15:0]       req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              rom_rd_en,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_rd_en,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              mode_ram
);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_accept_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (!req_ready && !rsp_valid) ##1 rsp_valid);

  p_rom_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> (req_valid && !req_write && !req_addr[15]));

  p_low_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd_en && !req_addr[14]) |-> (rom_addr[ROM_AW-1:14] == '0));

  p_ram_mode_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd_en && mode_ram) |-> (rom_addr[ROM_AW-1:ROM_AW-2] == 2'b00));

  p_ram_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> (req_valid && !req_write && req_addr[15:13] == 3'b101));

  p_ram_bank0_rom_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en && !mode_ram) |-> (ram_addr[RAM_AW-1:13] == '0));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !rom_rd_en && !ram_rd_en)
      |=> ##1 (rsp_valid && rsp_data == 8'h00));

  p_enables_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_rd_en && ram_rd_en));
endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rom_rd_en (rom_rd_en),
  .rom_addr  (rom_addr),
  .ram_rd_en (ram_rd_en),
  .ram_addr  (ram_addr),
  .mode_ram  (mode_ram)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic        rom_rd_en;
  logic [20:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic        ram_rd_en;
  logic [14:0] ram_addr;
  logic [7:0]  ram_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model of the banking state, kept from the requirements
  logic [4:0] m_lo = 5'd1;
  logic [1:0] m_hi = 2'd0;
  bit         m_mode = 1'b0;
  bit         m_ram_on = 1'b0;

  always #5 clk = ~clk;

  cart_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rom_rd_en(rom_rd_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_byte(logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ram_byte(logic [14:0] a);
    return a[7:0] ^ {a[14:13], 6'h00} ^ 8'h3C;
  endfunction

  // Synchronous memory models
  logic [7:0] rom_q = '0;
  logic [7:0] ram_q = '0;
  always_ff @(posedge clk) begin
    if (rom_rd_en) rom_q <= rom_byte(rom_addr);
    if (ram_rd_en) ram_q <= ram_byte(ram_addr);
  end
  assign rom_rdata = rom_q;
  assign ram_rdata = ram_q;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_rom(logic [15:0] a);
    logic [6:0] b;
    if (!a[14])      b = 7'd0;
    else if (m_mode) b = {2'b00, m_lo};
    else             b = {m_hi, m_lo};
    return {b, a[13:0]};
  endfunction

  function automatic logic [14:0] exp_ram(logic [15:0] a);
    return {(m_mode ? m_hi : 2'b00), a[12:0]};
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (!a[15]) begin
      case (a[14:13])
        2'd0: m_ram_on = (d[3:0] == 4'hA);
        2'd1: m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
        2'd2: m_hi = d[1:0];
        default: m_mode = d[0];
      endcase
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [7:0] exp_d;
    bit is_rom;
    bit is_ram;
    is_rom = !a[15];
    is_ram = (a[15:13] == 3'b101) && m_ram_on;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    check(req_ready == 1'b1, req, req_ready, 1);
    check(rom_rd_en == is_rom, req, rom_rd_en, is_rom);
    check(ram_rd_en == is_ram, req, ram_rd_en, is_ram);
    if (is_rom) check(rom_addr == exp_rom(a), req, rom_addr, exp_rom(a));
    if (is_ram) check(ram_addr == exp_ram(a), req, ram_addr, exp_ram(a));
    exp_d = is_rom ? rom_byte(exp_rom(a)) : (is_ram ? ram_byte(exp_ram(a)) : 8'h00);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R11", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11", rsp_valid, 1);
    check(rsp_data == exp_d, req, rsp_data, exp_d);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R11", rsp_valid, 0);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    do_read(16'h4000, "R1");  // bank 1, ROM mode
    do_read(16'hA000, "R1");  // RAM disabled -> 0
  endtask

  task automatic t_low_window;
    do_write(16'h2000, 8'h05);
    do_read(16'h1234, "R2");
    do_read(16'h3FFF, "R2");
  endtask

  task automatic t_upper_rom_mode;
    do_write(16'h4000, 8'h02);    // R10 upper bits
    do_read(16'h7FFF, "R3");
    do_read(16'h4001, "R10");
  endtask

  task automatic t_zero_bank;
    do_write(16'h3000, 8'h00);
    do_read(16'h4010, "R9");
    do_write(16'h2000, 8'hE0);    // low five bits zero
    do_read(16'h5555, "R9");
    do_write(16'h2000, 8'h1F);
    do_read(16'h6000, "R9");
  endtask

  task automatic t_ram_mode;
    do_write(16'h6000, 8'h01);    // R10 mode select
    do_read(16'h5000, "R4");
    do_write(16'h0000, 8'h1A);    // R8 enable
    do_read(16'hA123, "R5");
    do_read(16'hBFFF, "R8");
    do_write(16'h7000, 8'h00);    // back to ROM mode
    do_read(16'hA123, "R5");
  endtask

  task automatic t_ram_disable;
    do_write(16'h1000, 8'h0B);
    do_read(16'hA000, "R6");
    do_write(16'h1FFF, 8'hFA);
    do_read(16'hA001, "R8");
    do_write(16'h0001, 8'hA0);
    do_read(16'hB000, "R6");
  endtask

  task automatic t_unmapped;
    do_read(16'h8000, "R7");
    do_read(16'hC000, "R7");
    do_read(16'hFFFF, "R7");
  endtask

  task automatic t_outside_writes;
    do_write(16'h0000, 8'h0A);
    do_write(16'h8000, 8'h00);
    do_write(16'hA000, 8'h00);
    do_write(16'hC000, 8'h01);
    do_write(16'hFFFF, 8'h00);
    do_read(16'h7ABC, "R12");
    do_read(16'hA010, "R12");
  endtask

  task automatic t_backpressure;
    logic [7:0] exp_d;
    exp_d = rom_byte(exp_rom(16'h4321));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4321;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R11", req_ready, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11", rsp_valid, 1);
    check(rsp_data == exp_d, "R11", rsp_data, exp_d);
    req_addr = 16'h0000;      // request held valid, must not be taken
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_data == exp_d, "R11", rsp_data, exp_d);
      check(req_ready == 1'b0, "R11", req_ready, 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R11", rsp_valid, 0);
    check(req_ready == 1'b1, "R11", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_window();
    t_upper_rom_mode();
    t_zero_bank();
    t_ram_mode();
    t_ram_disable();
    t_unmapped();
    t_outside_writes();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule